// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line. The frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional even or odd parity bit, then a high stop period of one, one and a half or two bit times. The line idles high.

The bit rate comes from a divisor input. A baud divider makes one oversampling tick every `divisor` clocks, and one bit lasts sixteen ticks. Stop periods are counted in ticks, so a stop period of one and a half bits is exact. A producer offers a word with a valid/ready handshake. The word, the frame format and the divisor are all captured together at the handshake. After that the producer may change the inputs freely while the frame is on the line.

Top module: `serial_frame_tx`

## Requirements
- R1: The frame length code `cfg_len` selects the number of data bits: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Only that many low-order bits of `in_data` go on the line, and the frame ends exactly (1 + bits + parity bit + stop ticks/16) bit periods after it starts.
- R2: The data bits follow the start bit directly, least significant bit first, and each bit lasts one bit period.
- R3: The parity code `cfg_par` is decoded as follows: 2'b00 and 2'b11 mean no parity bit, 2'b01 means even and 2'b10 means odd. When parity is enabled, one bit follows the last data bit. With even parity the number of ones over the sent data bits plus the parity bit is even; with odd parity it is odd.
- R4: The stop code `cfg_stop` sets how long the line is held high at the end of a frame: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks, and 2'b10 or 2'b11 give 32 ticks. `in_ready` stays low until that hold is complete.
- R5: One bit period is 16 × D clocks. D is `cfg_div`, except that a value of 0 stands for 2^DIV_W.
- R6: The start bit is driven low. It begins on the clock after the edge at which `in_valid` and `in_ready` were both high.
- R7: `tx` is high during reset, after reset and whenever no frame is in progress. After reset `in_ready` is high and `busy` is low.
- R8: Data and configuration are captured only at the handshake. Changing them mid-frame, or raising `in_valid` while a frame is in progress, has no effect on the frame on the line and starts no extra frame.
- R9: `busy` rises together with the start bit and falls in the same cycle as `in_ready` rises. It is always the complement of `in_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Word to send; only the selected low bits are used |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Transmitter can accept a word |
| cfg_len | input | 2 | Data bit count code (5 to 8) |
| cfg_par | input | 2 | Parity mode code |
| cfg_stop | input | 2 | Stop period code |
| cfg_div | input | DIV_W | Clocks per oversampling tick; 0 means 2^DIV_W |
| tx | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |

## Verification
The bench builds the block with DIV_W = 4 and OSR = 16. The narrow divisor means a divisor code of 0, which stands for 16 clocks per tick, gives frames short enough to watch in full. That brings the wrap-to-maximum case into reach next to divisors of 1, 2 and 3. Every length, parity and stop code is used, including the alias codes for no parity and for two stop bits. One frame is disturbed mid-transfer by a burst of `in_valid` and changed inputs, and frames are also sent back to back.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  localparam int unsigned MAX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } seq_state_t;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  // data bit count from the length code: 5..8
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // stop hold in oversampling ticks
  function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned osr);
    case (code)
      2'b00:   return osr;
      2'b01:   return osr + osr / 2;
      default: return 2 * osr;
    endcase
  endfunction

  // parity over the low n bits; odd_mode inverts the even result
  function automatic logic frame_parity(input logic [MAX_BITS-1:0] d, input logic [3:0] n,
                                        input logic odd_mode);
    logic p;
    p = odd_mode;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (4'(i) < n) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/sftx_baud_tick.sv
module sftx_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE  = 1;
  localparam logic [DIV_W:0]   FULL = 1 << DIV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      div_q <= div_i;
      cnt_q <= div_i - ONE;   // wraps for 0: full 2^DIV_W period
    end else if (cnt_q == '0) begin
      cnt_q <= div_q - ONE;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign tick_o = (cnt_q == '0);

  // spacing checker: clocks between ticks must equal the decoded divisor
  logic [DIV_W:0] gap_q;
  logic           seen_q;
  logic [DIV_W:0] period_w;

  assign period_w = (div_q == '0) ? FULL : {1'b0, div_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (restart_i) seen_q <= 1'b1;
      if (restart_i || tick_o) gap_q <= {{DIV_W{1'b0}}, 1'b1};
      else                     gap_q <= gap_q + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && seen_q && !restart_i) |-> (gap_q == period_w)) else $error("tick spacing"); // R5

endmodule

// File: rtl/sftx_parity_gen.sv
module sftx_parity_gen
  import sftx_pkg::*;
(
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [1:0]          len_i,
  input  logic [1:0]          mode_i,
  output logic                par_en_o,
  output logic                par_bit_o
);
  assign par_en_o  = (mode_i == PAR_EVEN) || (mode_i == PAR_ODD);
  assign par_bit_o = frame_parity(data_i, data_bits(len_i), mode_i == PAR_ODD);
endmodule

// File: rtl/sftx_frame_seq.sv
module sftx_frame_seq
  import sftx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [1:0]          len_i,
  input  logic [1:0]          stop_i,
  input  logic                par_en_i,
  input  logic                par_bit_i,
  input  logic                tick_i,
  output logic                ready_o,
  output logic                busy_o,
  output logic                restart_o,
  output logic                tx_o
);
  localparam int SUB_W = $clog2(2 * OSR + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_ONE  = 1;

  seq_state_t          state_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic [3:0]          nbits_q;
  logic [3:0]          idx_q;
  logic                par_en_q;
  logic                par_bit_q;
  logic [SUB_W-1:0]    stop_lim_q;
  logic [SUB_W-1:0]    sub_q;
  logic                busy_q;

  // named internal events
  logic accept;
  logic bit_done;
  logic stop_done;
  logic seg_done;
  logic last_bit;

  assign ready_o   = (state_q == ST_IDLE);
  assign accept    = valid_i && ready_o;
  assign restart_o = accept;
  assign bit_done  = tick_i && (sub_q == SUB_LAST);
  assign stop_done = tick_i && (sub_q == stop_lim_q - SUB_ONE);
  assign seg_done  = (state_q == ST_STOP) ? stop_done : bit_done;
  assign last_bit  = (idx_q == nbits_q - 4'd1);
  assign busy_o    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      shreg_q    <= '0;
      nbits_q    <= 4'd8;
      idx_q      <= '0;
      par_en_q   <= 1'b0;
      par_bit_q  <= 1'b0;
      stop_lim_q <= SUB_W'(OSR);
      sub_q      <= '0;
      busy_q     <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && tick_i) begin
        sub_q <= seg_done ? '0 : sub_q + SUB_ONE;
      end
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q    <= ST_START;
            shreg_q    <= data_i;
            nbits_q    <= data_bits(len_i);
            idx_q      <= '0;
            par_en_q   <= par_en_i;
            par_bit_q  <= par_bit_i;
            stop_lim_q <= SUB_W'(stop_ticks(stop_i, OSR));
            sub_q      <= '0;
            busy_q     <= 1'b1;
          end
        end
        ST_START: begin
          if (seg_done) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (seg_done) begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 4'd1;
            if (last_bit) state_q <= par_en_q ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (seg_done) state_q <= ST_STOP;
        end
        ST_STOP: begin
          if (seg_done) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START: tx_o = 1'b0;
      ST_DATA:  tx_o = shreg_q[0];
      ST_PAR:   tx_o = par_bit_q;
      default:  tx_o = 1'b1;
    endcase
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_o) else $error("start bit"); // R6
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> tx_o) else $error("idle level"); // R7
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (tx_o && (sub_q < stop_lim_q))) else $error("stop hold"); // R4
  AST_DATA_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q < nbits_q)) else $error("data index"); // R1
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_o && $past(!ready_o)) |-> ($stable(nbits_q) && $stable(stop_lim_q) && $stable(par_en_q)))
    else $error("config moved"); // R8
  AST_BUSY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o != ready_o) else $error("busy/ready"); // R9

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sftx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       cfg_len,
  input  logic [1:0]       cfg_par,
  input  logic [1:0]       cfg_stop,
  input  logic [DIV_W-1:0] cfg_div,
  output logic             tx,
  output logic             busy
);
  logic tick_w;
  logic restart_w;
  logic par_en_w;
  logic par_bit_w;

  sftx_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart_w),
    .div_i     (cfg_div),
    .tick_o    (tick_w)
  );

  sftx_parity_gen u_par (
    .data_i    (in_data),
    .len_i     (cfg_len),
    .mode_i    (cfg_par),
    .par_en_o  (par_en_w),
    .par_bit_o (par_bit_w)
  );

  sftx_frame_seq #(.OSR(OSR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (in_valid),
    .data_i    (in_data),
    .len_i     (cfg_len),
    .stop_i    (cfg_stop),
    .par_en_i  (par_en_w),
    .par_bit_i (par_bit_w),
    .tick_i    (tick_w),
    .ready_o   (in_ready),
    .busy_o    (busy),
    .restart_o (restart_w),
    .tx_o      (tx)
  );

endmodule

// File: tb/sim_serial_frame_tx.sv
`timescale 1ns/1ps
module sim_serial_frame_tx;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    cfg_len = '0, cfg_par = '0, cfg_stop = '0;
  logic [DW-1:0] cfg_div = 4'd1;
  logic          tx, busy;

  int n_chk = 0, n_bad = 0, n_sent = 0, n_seen = 0;

  typedef struct {
    logic [7:0] data;
    logic [1:0] len, par, stop;
    logic [DW-1:0] div;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  serial_frame_tx #(.DIV_W(DW), .OSR(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cfg_div(cfg_div),
    .tx(tx), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: restates the frame from the requirements and samples mid-bit
  task automatic check_frame(input exp_t e);
    int dv, nb, stp, nline, off, tgt, t_all;
    bit pen, p;
    bit bits[12];
    dv    = (e.div == 0) ? (1 << DW) : int'(e.div);          // R5
    nb    = 5 + int'(e.len);                                // R1
    pen   = (e.par == 2'b01) || (e.par == 2'b10);            // R3
    stp   = (e.stop == 2'b00) ? 16 : ((e.stop == 2'b01) ? 24 : 32); // R4
    bits[0] = 1'b0;
    p = (e.par == 2'b10);
    for (int i = 0; i < nb; i++) begin
      bits[1 + i] = e.data[i];
      p ^= e.data[i];
    end
    nline = 1 + nb + (pen ? 1 : 0);
    if (pen) bits[1 + nb] = p;
    off = 0;
    for (int k = 0; k < nline; k++) begin
      tgt = 16 * dv * k + 8 * dv;
      repeat (tgt - off) @(negedge clk);
      off = tgt;
      chk(tx == bits[k], (k == 0) ? "R6 start" : ((k <= nb) ? "R2 data" : "R3 parity"),
          int'(tx), int'(bits[k]));
      if (k == 0) begin
        tgt = 16 * dv - 1;
        repeat (tgt - off) @(negedge clk);
        off = tgt;
        chk(tx == 1'b0, "R5 start end", int'(tx), 0);
        @(negedge clk); off++;
        chk(tx == bits[1], "R5 first data edge", int'(tx), int'(bits[1]));
      end
    end
    t_all = (16 * nline + stp) * dv;
    tgt = 16 * nline * dv + dv / 2;
    repeat (tgt - off) @(negedge clk);
    off = tgt;
    chk(tx == 1'b1, "R4 stop level", int'(tx), 1);
    tgt = t_all - 1;
    repeat (tgt - off) @(negedge clk);
    off = tgt;
    chk(tx == 1'b1 && in_ready == 1'b0, "R4 hold before ready", int'(in_ready), 0);
    chk(busy == 1'b1, "R9 busy in frame", int'(busy), 1);
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 frame length", int'(in_ready), 1);
    chk(busy == 1'b0, "R9 busy falls with ready", int'(busy), 0);
    chk(tx == 1'b1, "R7 idle after frame", int'(tx), 1);
    n_seen++;
  endtask

  initial begin : monitor
    bit prev_tx;
    exp_t e;
    prev_tx = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev_tx && !tx) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected frame", 1, 0);
        end else begin
          e = q.pop_front();
          check_frame(e);
        end
      end
      prev_tx = tx;
    end
  end

  task automatic send(input logic [7:0] d, input logic [1:0] len, input logic [1:0] par,
                      input logic [1:0] stp, input logic [DW-1:0] dv, input bit disturb);
    exp_t e;
    e.data = d; e.len = len; e.par = par; e.stop = stp; e.div = dv;
    @(negedge clk);
    in_data = d; cfg_len = len; cfg_par = par; cfg_stop = stp; cfg_div = dv;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    q.push_back(e);
    n_sent++;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = ~d; cfg_len = ~len; cfg_par = ~par; cfg_stop = ~stp; cfg_div = dv + 4'd3;
    if (disturb) begin
      repeat (20) @(negedge clk);
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      chk(in_ready == 1'b0, "R8 valid while busy", int'(in_ready), 0);
      in_valid = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    chk(tx == 1'b1, "R7 tx in reset", int'(tx), 1);
    chk(busy == 1'b0, "R7 busy in reset", int'(busy), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1 && in_ready == 1'b1, "R7 after reset", int'(in_ready), 1);
    chk(busy == 1'b0, "R7 busy after reset", int'(busy), 0);

    send(8'hA5, 2'b11, 2'b00, 2'b00, 4'd1, 1'b0);   // 8N1
    send(8'hFF, 2'b00, 2'b01, 2'b00, 4'd2, 1'b0);   // R1 5 bits, even
    send(8'h2D, 2'b01, 2'b10, 2'b01, 4'd3, 1'b1);   // 6 bits odd 1.5 stop, disturbed (R8)
    send(8'h55, 2'b10, 2'b01, 2'b10, 4'd1, 1'b0);   // 7 bits even 2 stop
    send(8'h80, 2'b11, 2'b10, 2'b11, 4'd0, 1'b0);   // divisor 0 -> 16 (R5)
    send(8'h3C, 2'b11, 2'b11, 2'b01, 4'd2, 1'b0);   // alias no parity (R3)
    send(8'h01, 2'b00, 2'b10, 2'b00, 4'd1, 1'b1);   // 5 bits odd, disturbed
    send(8'hC3, 2'b10, 2'b00, 2'b10, 4'd2, 1'b0);   // back to back
    send(8'h7E, 2'b11, 2'b01, 2'b00, 4'd1, 1'b0);

    while (n_seen < n_sent) @(negedge clk);
    repeat (400) @(negedge clk);
    chk(n_seen == n_sent && q.size() == 0, "R8 frame count", n_seen, n_sent);
    chk(tx == 1'b1, "R7 idle at end", int'(tx), 1);
    summary();
    $finish;
  end

endmodule